// File: doc/BRIEF.md
# Tagged Receive Byte Buffer

This block sits between a serial receive shifter and a byte-wide host read port. Each time the shifter finishes a character, it offers one byte here, together with three error bits: parity error, framing error and break. The block keeps the byte and its bits together as one entry. The host always sees the oldest entry on the data and tag outputs, and takes it with a pop strobe. A status-read strobe clears the sticky overrun flag.

The block also makes the flow-control signals the host side uses. It raises a trigger-level hit, chosen from four fill thresholds. It drives an active-low receive-ready output that follows one of two rules, picked by a transfer-mode bit. It raises a character timeout when data waits with no traffic. With the buffer enable low, the block acts as a single holding register. A flush input empties the storage in one cycle.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the buffer is empty: `fill`=0, `data_avail`=0, `overrun`=0, `timeout`=0 and `rx_rdy_n`=1.
- R2: Entries leave in the order they were written. Each entry carries its own data and tags. `rd_data`, `head_perr`, `head_ferr` and `head_brk` show the oldest entry, and all read 0 while the buffer is empty.
- R3: With `fifo_en`=1 the buffer holds 16 entries. A write to a full buffer without a pop in the same cycle is dropped and sets `overrun`. `overrun` stays set until a `stat_rd` cycle that carries no new drop. A drop in the same cycle as `stat_rd` leaves it set.
- R4: `trig_sel` picks the trigger level: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14 entries. `trig_hit` is 1 exactly when `fill` is at or above that level.
- R5: With `dma_mode`=0, `rx_rdy_n` is 0 exactly when at least one entry is held.
- R6: With `dma_mode`=1 and `fifo_en`=1, `rx_rdy_n` is 0 exactly when `trig_hit` or `timeout` is 1. It returns to 1 once the fill drops below the level and no timeout is pending.
- R7: With `fifo_en`=0 the capacity is 1 entry and the trigger level is 1 whatever `trig_sel` says. `rx_rdy_n` follows the R5 rule in both transfer modes. `timeout` never asserts. A second write before a pop is dropped and sets `overrun`.
- R8: With data held and no write, pop or flush, `timeout` rises in the cycle after the 640th `tick16` pulse (4 characters of 160 ticks). A write, a pop or a flush clears it and restarts the count.
- R9: `flush` empties the buffer in one cycle. The head outputs then read 0, and a write in the same cycle is dropped without setting `overrun`. `trig_sel` and `overrun` are not affected.
- R10: A pop while empty has no effect. A pop and a write in the same cycle on a full buffer are both done, with no overrun and `fill` unchanged.
- R11: Any change of `fifo_en` flushes the buffer on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 16-entry buffer, 0: single holding register |
| dma_mode | input | 1 | Receive-ready rule select |
| trig_sel | input | 2 | Trigger level code |
| flush | input | 1 | Empty the buffer |
| wr_en | input | 1 | Write strobe from the receive shifter |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error of the received byte |
| wr_ferr | input | 1 | Framing error of the received byte |
| wr_brk | input | 1 | Break flag of the received byte |
| rd_pop | input | 1 | Host pop of the head entry |
| stat_rd | input | 1 | Status read, clears overrun |
| tick16 | input | 1 | One pulse per 16x bit-clock tick |
| rd_data | output | 8 | Head entry data |
| head_perr | output | 1 | Head entry parity tag |
| head_ferr | output | 1 | Head entry framing tag |
| head_brk | output | 1 | Head entry break tag |
| data_avail | output | 1 | At least one entry held |
| overrun | output | 1 | Sticky dropped-byte flag |
| trig_hit | output | 1 | Fill at or above trigger level |
| rx_rdy_n | output | 1 | Active-low receive-ready |
| timeout | output | 1 | Character timeout pending |
| fill | output | 5 | Number of entries held |

## Verification
The assertions assume that `wr_en`, `rd_pop`, `flush` and `fifo_en` are sampled only at rising edges. They also assume that `fifo_en` does not change in the same cycle as a pop whose fill decrement is checked. The bench therefore drives every input one time unit after a rising edge and changes the buffer enable only in idle cycles. It pulses `tick16` only in cycles with no write or pop, so the timeout window starts from a known point.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    // threshold for a trigger code, scaled to the buffer depth (16 -> 1,4,8,14)
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            clr,
    input  rx_entry_t       wr_entry,
    output rx_entry_t       head,
    output logic [CW-1:0]   count
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } store_st_t;

    store_st_t st_d, st_q;
    rx_entry_t mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wptr = st_q.wptr + PW'(1);
            if (pop)  st_d.rptr = st_q.rptr + PW'(1);
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[st_q.wptr] <= wr_entry;
    end

    assign head  = (st_q.cnt == '0) ? '0 : mem_q[st_q.rptr];
    assign count = st_q.cnt;

    // R2: a pop always removes something that was there
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> (st_q.cnt != '0));
endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
    parameter int unsigned LIMIT = 640,
    localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic have_data,
    input  logic activity,
    input  logic tick,
    output logic expired
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          flag;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable || !have_data || activity) begin
            st_d = '0;
        end else if (tick && !st_q.flag) begin
            if (st_q.cnt == TW'(LIMIT - 1)) begin
                st_d.flag = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = st_q.flag;

    // R8: traffic restarts the window
    p_tmo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !expired);
    // R7: no timeout while single-register mode holds
    p_tmo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !expired);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH          = 16,
    parameter int unsigned TICKS_PER_CHAR = 160,
    parameter int unsigned TMO_CHARS      = 4,
    localparam int unsigned CW            = $clog2(DEPTH + 1),
    localparam int unsigned TMO_LIMIT     = TICKS_PER_CHAR * TMO_CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              dma_mode,
    input  logic [1:0]        trig_sel,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_perr,
    input  logic              wr_ferr,
    input  logic              wr_brk,
    input  logic              rd_pop,
    input  logic              stat_rd,
    input  logic              tick16,
    output logic [BYTE_W-1:0] rd_data,
    output logic              head_perr,
    output logic              head_ferr,
    output logic              head_brk,
    output logic              data_avail,
    output logic              overrun,
    output logic              trig_hit,
    output logic              rx_rdy_n,
    output logic              timeout,
    output logic [CW-1:0]     fill
);
    typedef struct packed {
        logic en;
        logic ovr;
    } top_st_t;

    top_st_t   st_d, st_q;
    rx_entry_t wr_entry, head;
    logic [CW-1:0] count, cap, level;
    logic clr, full, pop_ok, push_ok, drop, tmo;

    assign wr_entry = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: wr_data};
    assign clr      = flush || (fifo_en != st_q.en);
    assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
    assign level    = fifo_en ? CW'(trig_level(trig_sel, DEPTH)) : CW'(1);
    assign full     = (count >= cap);
    assign pop_ok   = rd_pop && (count != '0) && !clr;
    assign push_ok  = wr_en && !clr && (!full || pop_ok);
    assign drop     = wr_en && !clr && full && !pop_ok;

    always_comb begin
        st_d    = st_q;
        st_d.en = fifo_en;
        if (drop)         st_d.ovr = 1'b1;
        else if (stat_rd) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_ok),
        .pop      (pop_ok),
        .clr      (clr),
        .wr_entry (wr_entry),
        .head     (head),
        .count    (count)
    );

    rxf_timer #(.LIMIT(TMO_LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fifo_en),
        .have_data (count != '0),
        .activity  (wr_en || rd_pop || clr),
        .tick      (tick16),
        .expired   (tmo)
    );

    assign rd_data    = head.data;
    assign head_perr  = head.perr;
    assign head_ferr  = head.ferr;
    assign head_brk   = head.brk;
    assign fill       = count;
    assign data_avail = (count != '0);
    assign overrun    = st_q.ovr;
    assign timeout    = tmo;
    assign trig_hit   = (count >= level);
    assign rx_rdy_n   = (fifo_en && dma_mode) ? !(trig_hit || tmo) : !data_avail;

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $past(!fifo_en)) |-> fill <= CW'(1));
    p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $stable(fifo_en) && wr_en && fill == CW'(DEPTH) && !rd_pop && !flush) |=> overrun);
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !data_avail);
    p_pop_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && fill != '0 && !wr_en && !flush && $stable(fifo_en)) |=> fill == $past(fill) - CW'(1));
    p_tmo_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> data_avail);
endmodule

// File: tb/rx_tag_fifo_bench.sv
module rx_tag_fifo_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1, dma_mode = 1'b0, flush = 1'b0, wr_en = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic wr_perr = 1'b0, wr_ferr = 1'b0, wr_brk = 1'b0;
    logic rd_pop = 1'b0, stat_rd = 1'b0, tick16 = 1'b0;
    logic [7:0] rd_data;
    logic head_perr, head_ferr, head_brk, data_avail, overrun, trig_hit, rx_rdy_n, timeout;
    logic [4:0] fill;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rx_tag_fifo u_rx_tag_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_sel(trig_sel), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_pop(rd_pop),
        .stat_rd(stat_rd), .tick16(tick16), .rd_data(rd_data), .head_perr(head_perr),
        .head_ferr(head_ferr), .head_brk(head_brk), .data_avail(data_avail),
        .overrun(overrun), .trig_hit(trig_hit), .rx_rdy_n(rx_rdy_n),
        .timeout(timeout), .fill(fill)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] tags);
        wr_en = 1'b1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = tags;
        step();
        wr_en = 1'b0; {wr_brk, wr_ferr, wr_perr} = 3'b000;
    endtask

    task automatic pop();
        rd_pop = 1'b1; step(); rd_pop = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1; step(); flush = 1'b0;
    endtask

    task automatic clear_ovr();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fill", fill, 0);
        chk("R1 data_avail", data_avail, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 timeout", timeout, 0);
        chk("R1 rx_rdy_n", rx_rdy_n, 1);
    endtask

    task automatic t_order_tags();
        do_flush();
        chk("R2 empty data", rd_data, 0);
        push(8'hA1, 3'b001);
        push(8'hB2, 3'b010);
        push(8'hC3, 3'b100);
        for (int i = 0; i < 3; i++) begin
            chk("R2 data", rd_data, (i == 0) ? 8'hA1 : (i == 1) ? 8'hB2 : 8'hC3);
            chk("R2 tags", {head_brk, head_ferr, head_perr}, 1 << i);
            pop();
        end
        chk("R2 empty tags", {head_brk, head_ferr, head_perr}, 0);
    endtask

    task automatic t_full_overrun();
        do_flush(); clear_ovr();
        for (int i = 0; i < 16; i++) push(8'(i + 16), 3'b000);
        chk("R3 fill 16", fill, 16);
        chk("R3 no ovr yet", overrun, 0);
        push(8'hEE, 3'b111);
        chk("R3 fill held", fill, 16);
        chk("R3 ovr set", overrun, 1);
        wr_en = 1'b1; stat_rd = 1'b1; wr_data = 8'hEF; step();
        wr_en = 1'b0; stat_rd = 1'b0;
        chk("R3 ovr set wins over read", overrun, 1);
        clear_ovr();
        chk("R3 ovr cleared", overrun, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R3 drop kept order", rd_data, i + 16);
            pop();
        end
    endtask

    task automatic t_trigger();
        dma_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            automatic int lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            trig_sel = 2'(s);
            do_flush();
            for (int i = 0; i < lvl - 1; i++) push(8'(i), 3'b000);
            chk("R4 below level", trig_hit, 0);
            chk("R6 rdy high below", rx_rdy_n, 1);
            push(8'h55, 3'b000);
            chk("R4 at level", trig_hit, 1);
            chk("R6 rdy low at level", rx_rdy_n, 0);
        end
        trig_sel = 2'b01;
        do_flush();
        for (int i = 0; i < 4; i++) push(8'(i), 3'b000);
        pop();
        chk("R6 rdy high after drop", rx_rdy_n, 1);
        dma_mode = 1'b0;
        #0;
        chk("R5 rdy low with data", rx_rdy_n, 0);
        do_flush();
        chk("R5 rdy high empty", rx_rdy_n, 1);
    endtask

    task automatic t_timeout();
        dma_mode = 1'b1; trig_sel = 2'b11;
        do_flush();
        push(8'h11, 3'b000); push(8'h22, 3'b000);
        tick16 = 1'b1;
        for (int i = 0; i < 639; i++) step();
        chk("R8 not yet", timeout, 0);
        step();
        tick16 = 1'b0;
        chk("R8 timeout", timeout, 1);
        chk("R6 rdy low on timeout", rx_rdy_n, 0);
        pop();
        chk("R8 pop clears", timeout, 0);
        chk("R6 rdy high after pop", rx_rdy_n, 1);
        dma_mode = 1'b0;
    endtask

    task automatic t_flush();
        trig_sel = 2'b01; clear_ovr();
        for (int i = 0; i < 5; i++) push(8'hF0, 3'b111);
        for (int i = 0; i < 16; i++) push(8'h01, 3'b000);
        chk("R9 ovr before flush", overrun, 1);
        flush = 1'b1; wr_en = 1'b1; wr_data = 8'h77; step();
        flush = 1'b0; wr_en = 1'b0;
        chk("R9 empty", fill, 0);
        chk("R9 data zero", rd_data, 0);
        chk("R9 tags zero", {head_brk, head_ferr, head_perr}, 0);
        chk("R9 ovr untouched", overrun, 1);
        clear_ovr();
        for (int i = 0; i < 3; i++) push(8'h02, 3'b000);
        chk("R9 trig kept below", trig_hit, 0);
        push(8'h03, 3'b000);
        chk("R9 trig kept at", trig_hit, 1);
        do_flush();
    endtask

    task automatic t_edges();
        pop();
        chk("R10 pop empty fill", fill, 0);
        chk("R10 pop empty avail", data_avail, 0);
        for (int i = 0; i < 16; i++) push(8'(i + 64), 3'b000);
        rd_pop = 1'b1; wr_en = 1'b1; wr_data = 8'h99; step();
        rd_pop = 1'b0; wr_en = 1'b0;
        chk("R10 fill same", fill, 16);
        chk("R10 no ovr", overrun, 0);
        chk("R10 head advanced", rd_data, 65);
        for (int i = 0; i < 15; i++) pop();
        chk("R10 new byte last", rd_data, 8'h99);
        pop();
    endtask

    task automatic t_single();
        fifo_en = 1'b0; dma_mode = 1'b1; trig_sel = 2'b11;
        step();
        push(8'h5A, 3'b010);
        chk("R7 fill 1", fill, 1);
        chk("R7 trig level 1", trig_hit, 1);
        chk("R7 rdy low", rx_rdy_n, 0);
        push(8'hA5, 3'b000);
        chk("R7 second dropped", fill, 1);
        chk("R7 overrun", overrun, 1);
        chk("R7 first kept", rd_data, 8'h5A);
        tick16 = 1'b1;
        for (int i = 0; i < 700; i++) step();
        tick16 = 1'b0;
        chk("R7 no timeout", timeout, 0);
        clear_ovr();
        fifo_en = 1'b1; dma_mode = 1'b0; step();
        chk("R11 flush on enable", fill, 0);
        push(8'h01, 3'b000); push(8'h02, 3'b000); push(8'h03, 3'b000);
        chk("R11 filled", fill, 3);
        fifo_en = 1'b0; step();
        chk("R11 flush on disable", fill, 0);
        fifo_en = 1'b1; step();
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step(); step();
        t_reset();
        t_order_tags();
        t_full_overrun();
        t_trigger();
        t_timeout();
        t_flush();
        t_edges();
        t_single();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule